// File: doc/BRIEF.md
# Byte Shift, Rotate and Bit-Field Unit

This unit carries out the single-operand byte transformations of a small 8-bit processor datapath. It takes one byte, an operation code, a bit index and the current flag nibble. One cycle later it returns the transformed byte, the next flag nibble, and two write enables. The enables tell the register file whether to store the byte and whether to update the flags.

The operations are four rotates (circular, or through the carry flag, in either direction), a left shift that fills with zero, arithmetic and logical right shifts, and a nibble exchange. There are also three single-bit operations: test, force to one and force to zero. A second set of four rotates is meant for the accumulator's short encodings. These move the data exactly like the general rotates but always report a clear zero flag.

Operand fetch, read-modify-write sequencing through memory, and instruction decode belong to the surrounding pipeline. The unit sees only the already-fetched byte and an operation code.

Top module: `byte_bitop_unit`

## Requirements
- R1: Each operation presented with `in_valid` high is reflected on the outputs one clock later, with `out_valid` high for exactly that cycle. Reset clears `out_valid`, `result`, `flags_out` and both enables.
- R2: Code 0 rotates left circularly: the old bit 7 goes to bit 0 and to C. Code 1 rotates right circularly: the old bit 0 goes to bit 7 and to C.
- R3: Code 2 rotates left through carry: the old C enters bit 0 and the old bit 7 becomes C. Code 3 rotates right through carry: the old C enters bit 7 and the old bit 0 becomes C.
- R4: Code 4 shifts left with a zero into bit 0 and the old bit 7 into C. Code 5 shifts right, keeps bit 7, and puts the old bit 0 into C. Code 6 shifts right with a zero into bit 7 and the old bit 0 into C.
- R5: For codes 0 to 6, Z is set exactly when the result byte is zero, N and H are cleared, and C is the bit shifted out. Flags are packed {Z,N,H,C} in bits 3..0 of `flags_in` and `flags_out`.
- R6: Codes 11, 12, 13 and 14 move the data like codes 0, 1, 2 and 3 respectively, but force Z, N and H to 0.
- R7: Code 7 exchanges the upper and lower nibbles, sets Z from the result, and clears N, H and C.
- R8: Code 8 tests the bit selected by `bit_idx`. Z becomes the inverse of that bit, N is cleared, H is set, C keeps its input value, and `result` carries the operand unchanged.
- R9: Code 9 forces the indexed bit to 1 and code 10 forces it to 0. All other bits are kept and `flags_out` equals `flags_in`.
- R10: `result_we` is low only for codes 8 and 15, and `flag_we` is low only for codes 9, 10 and 15.
- R11: Code 15 is reserved. It passes the operand and the flags through unchanged with both enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see requirements) |
| operand | input | 8 | Byte to transform |
| bit_idx | input | 3 | Bit index for codes 8, 9 and 10 |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Outputs hold a result this cycle |
| result | output | 8 | Transformed byte |
| flags_out | output | 4 | Next flags {Z,N,H,C} |
| result_we | output | 1 | Store `result` into the destination |
| flag_we | output | 1 | Store `flags_out` into the flag register |

## Verification
The bench targets the cases where a plausible mistake becomes visible:
- A through-carry rotate of 0x80 with C clear yields zero. A unit that dropped the zero detect would leave Z clear there. The accumulator variant of the same rotate must leave Z clear, so a unit that shared the general flag path would wrongly set it.
- A right arithmetic shift of 0x81 exposes a fill that uses zero instead of the sign bit.
- A bit test run with C set catches a unit that clears C.
- Setting bit 0 and clearing bit 7 catch an off-by-one or reversed index decode.
- The reserved code and the enable checks catch a unit that writes back a test result or touches the flags on a set or clear.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

   typedef enum logic [3:0] {
      OP_ROTL_CIRC      = 4'd0,
      OP_ROTR_CIRC      = 4'd1,
      OP_ROTL_CARRY     = 4'd2,
      OP_ROTR_CARRY     = 4'd3,
      OP_SHL_ZERO       = 4'd4,
      OP_SHR_SIGN       = 4'd5,
      OP_SHR_ZERO       = 4'd6,
      OP_NIB_SWAP       = 4'd7,
      OP_BIT_TEST       = 4'd8,
      OP_BIT_SET        = 4'd9,
      OP_BIT_CLR        = 4'd10,
      OP_ACC_ROTL_CIRC  = 4'd11,
      OP_ACC_ROTR_CIRC  = 4'd12,
      OP_ACC_ROTL_CARRY = 4'd13,
      OP_ACC_ROTR_CARRY = 4'd14,
      OP_RESERVED       = 4'd15
   } bitop_e;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } flags_t;

   // shift/rotate kinds understood by the shifter core
   localparam logic [2:0] SK_ROTL_CIRC  = 3'd0;
   localparam logic [2:0] SK_ROTR_CIRC  = 3'd1;
   localparam logic [2:0] SK_ROTL_CARRY = 3'd2;
   localparam logic [2:0] SK_ROTR_CARRY = 3'd3;
   localparam logic [2:0] SK_SHL_ZERO   = 3'd4;
   localparam logic [2:0] SK_SHR_SIGN   = 3'd5;
   localparam logic [2:0] SK_SHR_ZERO   = 3'd6;

   // modes understood by the bit-field core
   localparam logic [1:0] BF_SWAP = 2'd0;
   localparam logic [1:0] BF_TEST = 2'd1;
   localparam logic [1:0] BF_SET  = 2'd2;
   localparam logic [1:0] BF_CLR  = 2'd3;

endpackage

// File: rtl/shift_rot_core.sv
module shift_rot_core
   import bitops_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [2:0]        kind,
   input  logic [DATA_W-1:0] din,
   input  logic              cin,
   output logic [DATA_W-1:0] dout,
   output logic              cout
);

   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("shift_rot_core: DATA_W must be at least 2");
      end
   endgenerate

   always_comb begin
      dout = din;
      cout = cin;
      unique case (kind)
         SK_ROTL_CIRC: begin
            dout = {din[MSB-1:0], din[MSB]};
            cout = din[MSB];
         end
         SK_ROTR_CIRC: begin
            dout = {din[0], din[MSB:1]};
            cout = din[0];
         end
         SK_ROTL_CARRY: begin
            dout = {din[MSB-1:0], cin};
            cout = din[MSB];
         end
         SK_ROTR_CARRY: begin
            dout = {cin, din[MSB:1]};
            cout = din[0];
         end
         SK_SHL_ZERO: begin
            dout = {din[MSB-1:0], 1'b0};
            cout = din[MSB];
         end
         SK_SHR_SIGN: begin
            dout = {din[MSB], din[MSB:1]};
            cout = din[0];
         end
         SK_SHR_ZERO: begin
            dout = {1'b0, din[MSB:1]};
            cout = din[0];
         end
         default: begin
            dout = din;
            cout = cin;
         end
      endcase
   end

endmodule

// File: rtl/bit_field_core.sv
module bit_field_core
   import bitops_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W),
   localparam int HALF_W = DATA_W / 2
) (
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] din,
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] dout,
   output logic              sel_bit
);

   logic [DATA_W-1:0] mask;

   generate
      if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
         $error("bit_field_core: DATA_W must be even and at least 4");
      end
      for (genvar g = 0; g < DATA_W; g++) begin : g_mask
         assign mask[g] = (idx == IDX_W'(g));
      end
   endgenerate

   assign sel_bit = |(din & mask);

   always_comb begin
      unique case (mode)
         BF_SWAP: dout = {din[HALF_W-1:0], din[DATA_W-1:HALF_W]};
         BF_SET:  dout = din | mask;
         BF_CLR:  dout = din & ~mask;
         default: dout = din;
      endcase
   end

endmodule

// File: rtl/byte_bitop_unit.sv
module byte_bitop_unit
   import bitops_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] operand,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic [3:0]        flags_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic [3:0]        flags_out,
   output logic              result_we,
   output logic              flag_we
);

   bitop_e            opc;
   flags_t            fin;
   logic              is_acc;
   logic [3:0]        acc_off;
   logic [2:0]        sr_kind;
   logic [DATA_W-1:0] sr_res;
   logic              sr_c;
   logic [1:0]        bf_mode;
   logic [DATA_W-1:0] bf_res;
   logic              bf_bit;

   logic [DATA_W-1:0] nxt_res;
   flags_t            nxt_fl;
   logic              nxt_rwe;
   logic              nxt_fwe;

   assign opc     = bitop_e'(op);
   assign fin     = flags_t'(flags_in);
   assign is_acc  = (opc == OP_ACC_ROTL_CIRC)  || (opc == OP_ACC_ROTR_CIRC) ||
                    (opc == OP_ACC_ROTL_CARRY) || (opc == OP_ACC_ROTR_CARRY);
   assign acc_off = op - 4'd11;
   assign sr_kind = is_acc ? acc_off[2:0] : op[2:0];

   always_comb begin
      unique case (opc)
         OP_BIT_TEST: bf_mode = BF_TEST;
         OP_BIT_SET:  bf_mode = BF_SET;
         OP_BIT_CLR:  bf_mode = BF_CLR;
         default:     bf_mode = BF_SWAP;
      endcase
   end

   shift_rot_core #(.DATA_W(DATA_W)) u_shift (
      .kind (sr_kind),
      .din  (operand),
      .cin  (fin.c),
      .dout (sr_res),
      .cout (sr_c)
   );

   bit_field_core #(.DATA_W(DATA_W)) u_field (
      .mode    (bf_mode),
      .din     (operand),
      .idx     (bit_idx),
      .dout    (bf_res),
      .sel_bit (bf_bit)
   );

   always_comb begin
      nxt_res = operand;
      nxt_fl  = fin;
      nxt_rwe = 1'b0;
      nxt_fwe = 1'b0;
      unique case (opc)
         OP_ROTL_CIRC, OP_ROTR_CIRC, OP_ROTL_CARRY, OP_ROTR_CARRY,
         OP_SHL_ZERO, OP_SHR_SIGN, OP_SHR_ZERO: begin
            nxt_res = sr_res;
            nxt_fl  = '{z: (sr_res == '0), n: 1'b0, h: 1'b0, c: sr_c};
            nxt_rwe = 1'b1;
            nxt_fwe = 1'b1;
         end
         OP_ACC_ROTL_CIRC, OP_ACC_ROTR_CIRC,
         OP_ACC_ROTL_CARRY, OP_ACC_ROTR_CARRY: begin
            nxt_res = sr_res;
            nxt_fl  = '{z: 1'b0, n: 1'b0, h: 1'b0, c: sr_c};
            nxt_rwe = 1'b1;
            nxt_fwe = 1'b1;
         end
         OP_NIB_SWAP: begin
            nxt_res = bf_res;
            nxt_fl  = '{z: (bf_res == '0), n: 1'b0, h: 1'b0, c: 1'b0};
            nxt_rwe = 1'b1;
            nxt_fwe = 1'b1;
         end
         OP_BIT_TEST: begin
            nxt_res = operand;
            nxt_fl  = '{z: ~bf_bit, n: 1'b0, h: 1'b1, c: fin.c};
            nxt_rwe = 1'b0;
            nxt_fwe = 1'b1;
         end
         OP_BIT_SET, OP_BIT_CLR: begin
            nxt_res = bf_res;
            nxt_fl  = fin;
            nxt_rwe = 1'b1;
            nxt_fwe = 1'b0;
         end
         default: begin
            nxt_res = operand;
            nxt_fl  = fin;
            nxt_rwe = 1'b0;
            nxt_fwe = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         flags_out <= '0;
         result_we <= 1'b0;
         flag_we   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= nxt_res;
            flags_out <= nxt_fl;
            result_we <= nxt_rwe;
            flag_we   <= nxt_fwe;
         end
      end
   end

   // R1: one-cycle latency of the valid strobe
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R2: circular left rotate puts the same bit in bit 0 and carry
   p_circ_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd0) |=> (result[0] == flags_out[0]));

   // R6: accumulator rotates never report Z, N or H
   p_acc_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op >= 4'd11 && op <= 4'd14) |=> (flags_out[3:1] == 3'b000));

   // R7: nibble exchange clears N, H and C
   p_swap_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd7) |=> (flags_out[2:0] == 3'b000));

   // R8: bit test sets H, keeps C and does not write the byte
   p_test_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd8) |=>
         (!result_we && flags_out[1] && flags_out[0] == $past(flags_in[0])));

   // R9: set forces the bit and leaves the flags as they were
   p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd9) |=>
         (result[$past(bit_idx)] && !flag_we && flags_out == $past(flags_in)));
   p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd10) |=>
         (!result[$past(bit_idx)] && !flag_we && flags_out == $past(flags_in)));

   // R11: reserved code writes nothing
   p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd15) |=> (!result_we && !flag_we));

endmodule

// File: tb/byte_bitop_unit_tb.sv
`timescale 1ns/1ps
module byte_bitop_unit_tb;

   typedef struct {
      logic [3:0] op;
      logic [7:0] res;
      logic [3:0] fl;
      logic       rwe;
      logic       fwe;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] op = '0;
   logic [7:0] operand = '0;
   logic [2:0] bit_idx = '0;
   logic [3:0] flags_in = '0;
   logic       out_valid;
   logic [7:0] result;
   logic [3:0] flags_out;
   logic       result_we;
   logic       flag_we;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   byte_bitop_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op        (op),
      .operand   (operand),
      .bit_idx   (bit_idx),
      .flags_in  (flags_in),
      .out_valid (out_valid),
      .result    (result),
      .flags_out (flags_out),
      .result_we (result_we),
      .flag_we   (flag_we)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string data_tag(input logic [3:0] o);
      if (o <= 4'd1) return "R2";
      if (o <= 4'd3) return "R3";
      if (o <= 4'd6) return "R4";
      if (o == 4'd7) return "R7";
      if (o == 4'd8) return "R8";
      if (o <= 4'd10) return "R9";
      if (o <= 4'd14) return "R6";
      return "R11";
   endfunction

   function automatic string flag_tag(input logic [3:0] o);
      if (o <= 4'd6) return "R5";
      return data_tag(o);
   endfunction

   // independent model written from the requirements
   function automatic exp_t model(input logic [3:0] o, input logic [7:0] d,
                                  input logic [2:0] ix, input logic [3:0] f);
      exp_t e;
      logic c;
      logic [3:0] g;
      c = f[0];
      e.op = o; e.res = d; e.fl = f; e.rwe = 1'b1; e.fwe = 1'b1;
      g = (o >= 4'd11 && o <= 4'd14) ? o - 4'd11 : o;
      if (o <= 4'd6 || (o >= 4'd11 && o <= 4'd14)) begin
         case (g)
            4'd0: begin e.res = {d[6:0], d[7]}; c = d[7]; end
            4'd1: begin e.res = {d[0], d[7:1]}; c = d[0]; end
            4'd2: begin e.res = {d[6:0], f[0]}; c = d[7]; end
            4'd3: begin e.res = {f[0], d[7:1]}; c = d[0]; end
            4'd4: begin e.res = {d[6:0], 1'b0}; c = d[7]; end
            4'd5: begin e.res = {d[7], d[7:1]}; c = d[0]; end
            default: begin e.res = {1'b0, d[7:1]}; c = d[0]; end
         endcase
         e.fl = {(o <= 4'd6) ? (e.res == 8'h00) : 1'b0, 1'b0, 1'b0, c};
      end else if (o == 4'd7) begin
         e.res = {d[3:0], d[7:4]};
         e.fl = {(e.res == 8'h00), 3'b000};
      end else if (o == 4'd8) begin
         e.fl = {~d[ix], 1'b0, 1'b1, f[0]};
         e.rwe = 1'b0;
      end else if (o == 4'd9) begin
         e.res[ix] = 1'b1; e.fwe = 1'b0;
      end else if (o == 4'd10) begin
         e.res[ix] = 1'b0; e.fwe = 1'b0;
      end else begin
         e.rwe = 1'b0; e.fwe = 1'b0;
      end
      return e;
   endfunction

   task automatic drive(input logic [3:0] o, input logic [7:0] d,
                        input logic [2:0] ix, input logic [3:0] f);
      @(negedge clk);
      in_valid = 1'b1; op = o; operand = d; bit_idx = ix; flags_in = f;
      sb_q.push_back(model(o, d, ix, f));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         op = 4'hF; operand = 8'hFF; flags_in = 4'hF;
      end
   endtask

   // monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R1 unexpected out_valid", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(result == e.res, data_tag(e.op), result, e.res);
            check(flags_out == e.fl, flag_tag(e.op), flags_out, e.fl);
            check({result_we, flag_we} == {e.rwe, e.fwe}, "R10 enables",
                  {result_we, flag_we}, {e.rwe, e.fwe});
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!out_valid && result == 8'h00 && flags_out == 4'h0 && !result_we && !flag_we,
            "R1 reset state", {out_valid, result, flags_out, result_we, flag_we}, 0);
      rst_n = 1'b1;
      idle(2);
      check(!out_valid, "R1 idle after reset", out_valid, 0);

      // directed corners
      drive(4'd2, 8'h80, 3'd0, 4'b0000);   // R3 through-carry to zero: Z=1,C=1
      drive(4'd13, 8'h80, 3'd0, 4'b0000);  // R6 same data, Z forced 0
      drive(4'd5, 8'h81, 3'd0, 4'b0000);   // R4 sign fill -> C0, C=1
      drive(4'd6, 8'h81, 3'd0, 4'b0000);   // R4 zero fill -> 40
      drive(4'd0, 8'h80, 3'd0, 4'b0000);   // R2 -> 01, C=1
      drive(4'd1, 8'h01, 3'd0, 4'b0000);   // R2 -> 80, C=1
      drive(4'd3, 8'h01, 3'd0, 4'b0001);   // R3 -> 80, C=1
      drive(4'd7, 8'hF0, 3'd0, 4'b1111);   // R7 -> 0F, flags 0
      drive(4'd7, 8'h00, 3'd0, 4'b0001);   // R7 zero -> Z=1, C cleared
      drive(4'd8, 8'h7F, 3'd7, 4'b0001);   // R8 bit 7 clear, C kept
      drive(4'd8, 8'h80, 3'd7, 4'b1000);   // R8 bit 7 set, C kept 0
      drive(4'd9, 8'h00, 3'd0, 4'b1010);   // R9 set bit 0 -> 01
      drive(4'd10, 8'hFF, 3'd7, 4'b0101);  // R9 clear bit 7 -> 7F
      drive(4'd15, 8'h3C, 3'd2, 4'b1001);  // R11 reserved
      drive(4'd4, 8'h80, 3'd0, 4'b0000);   // R4/R5 shift out to zero
      idle(3);
      check(!out_valid && sb_q.size() == 0, "R1 drained", out_valid, 0);

      // sweep every code over several patterns and carry values
      for (int o = 0; o < 16; o++) begin
         for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 2; c++) begin
               logic [7:0] pat;
               case (p)
                  0: pat = 8'h00;
                  1: pat = 8'h01;
                  2: pat = 8'h80;
                  3: pat = 8'hA5;
                  4: pat = 8'h5A;
                  default: pat = 8'hFF;
               endcase
               drive(4'(o), pat, 3'(p + c * 3), {c[0], c[0], ~c[0], c[0]});
            end
         end
         if (o == 7) idle(1);
      end
      idle(3);
      check(!out_valid && sb_q.size() == 0, "R1 drained after sweep", sb_q.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule